// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It runs on the conversion clock. A convert-start pulse presets the code register while it is high, and the conversion begins once the pulse is released. From then on the block decides one bit per clock, most significant first. In each cycle it drives a trial code to an external DAC and reads back a single comparator decision. The comparator, DAC, reference and clock source all sit outside the block.

Each decided bit appears on a non-return-to-zero serial output as soon as it is known, and an inverted copy of that stream is driven alongside it. An end-of-conversion flag stays high for the whole conversion. A short-cycle select can stop the conversion after fewer bits, for callers that need speed more than resolution. The finished word is captured into a parallel result register. A static input can present that word as two's complement by inverting its top bit, which suits bipolar ranges coded as offset binary.

The resolution `W` is a parameter, 12 by default. Any value of at least 6 is accepted, so 10 is supported.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_n` is low, `eoc_o` is 0, `ser_o` is 0 and `ser_n_o` is 1. `trial_o` and the raw result both hold the preset code, in which bit W-1 is 0 and every lower bit is 1.
- R2: At any rising clock edge where `start_i` is sampled 1, `trial_o` and the raw result are loaded with the preset code, `ser_o` is cleared and `eoc_o` is 0 after that edge. Holding `start_i` high starts nothing.
- R3: At the first rising edge where `start_i` is sampled 0 after being sampled 1, the conversion begins and `eoc_o` rises. `eoc_o` then stays high for exactly N clock cycles, where N is the selected bit count.
- R4: While bit k is under trial, `trial_o` carries the bits already decided, a 1 in bit k and 0 in every bit below k. At the next edge, bit k is cleared if `cmp_below_i` is 1 (input below the DAC level) and kept otherwise. With an ideal comparator whose first code transition lies at +1/2 LSB, the full-resolution result is min(floor((2·input/LSB + 1)/2), 2^W − 1).
- R5: `res_sel_i` selects N: value 1 gives W−2 bits, value 2 gives W−4 bits, and values 0 or 3 give W bits. Bits left undecided by a short cycle read 1 in the result.
- R6: After each deciding edge, `ser_o` carries the bit just decided, MSB first, and it holds the last bit after the conversion ends. `ser_n_o` is always the inverse of `ser_o`.
- R7: The raw result register changes only at the edge that ends a conversion, taking the final code there, or at a preset (R2). It does not change during a conversion or while idle.
- R8: When `twos_i` is 1, `result_o` is the raw result with bit W−1 inverted. When `twos_i` is 0, `result_o` is the raw result unchanged.
- R9: `start_i` sampled 1 during a conversion aborts it. `eoc_o` is 0 after that edge and the preset of R2 applies.
- R10: `res_sel_i` is latched when a conversion begins. Changing it during the conversion does not change that conversion's length or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert-start level: high presets, release starts |
| cmp_below_i | input | 1 | Comparator: 1 when the analog input is below the DAC level |
| res_sel_i | input | 2 | Short-cycle select (0/3 full, 1 = W−2, 2 = W−4 bits) |
| twos_i | input | 1 | 1 inverts the MSB of the parallel result |
| trial_o | output | W | Trial code to the DAC |
| result_o | output | W | Parallel conversion result |
| eoc_o | output | 1 | High for the duration of a conversion |
| ser_o | output | 1 | NRZ serial stream of decided bits, MSB first |
| ser_n_o | output | 1 | Inverse of ser_o |

## Verification
The bound checker checks four things on every cycle: that `eoc_o` rises one edge after start is released, that a held start keeps `eoc_o` low, that the raw result stays frozen both during a conversion and while idle, and that a conversion which is not aborted lasts exactly the latched bit count. Only the bench scenarios can show that the comparator decisions produce the right code. Those scenarios also check the serial stream's order against that code, the fill of undecided bits at each short-cycle setting, the two's-complement view, and recovery after an abort. They drive an ideal comparator with a half-LSB offset over corner and random inputs.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    RES_FULL  = 2'd0,
    RES_LESS2 = 2'd1,
    RES_LESS4 = 2'd2,
    RES_FULLB = 2'd3
  } res_sel_e;

  // Number of bits decided for a given short-cycle selection.
  function automatic int bits_for_sel(input int w, input logic [1:0] sel);
    case (res_sel_e'(sel))
      RES_LESS2: return w - 2;
      RES_LESS4: return w - 4;
      default:   return w;
    endcase
  endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic rise_o,
  output logic fall_o
);
  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  // rise: preset request; fall: conversion launch
  assign rise_o = start_i & ~start_q;
  assign fall_o = ~start_i & start_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic [1:0]           res_sel_i,
  output logic                 busy_o,
  output logic [$clog2(W)-1:0] pos_o,
  output logic                 last_o
);
  localparam int IW = $clog2(W);

  logic          busy_q, busy_d;
  logic [IW-1:0] pos_q, pos_d;
  logic [IW-1:0] stop_q, stop_d;
  logic          en;

  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    stop_d = stop_q;
    if (rise_i) begin
      busy_d = 1'b0;
    end else if (fall_i) begin
      busy_d = 1'b1;
      pos_d  = IW'(W - 1);
      stop_d = IW'(W - sar_pkg::bits_for_sel(W, res_sel_i));
    end else if (busy_q) begin
      if (pos_q == stop_q) busy_d = 1'b0;
      else                 pos_d  = pos_q - 1'b1;
    end
  end

  assign en = rise_i | fall_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      stop_q <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
      stop_q <= stop_d;
    end
  end

  assign busy_o = busy_q;
  assign pos_o  = pos_q;
  assign last_o = busy_q & (pos_q == stop_q);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 busy_i,
  input  logic                 last_i,
  input  logic [$clog2(W)-1:0] pos_i,
  input  logic                 cmp_below_i,
  output logic [W-1:0]         trial_o,
  output logic [W-1:0]         result_o,
  output logic                 ser_o
);
  localparam logic [W-1:0] PRESET  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, code_d;
  logic [W-1:0] res_q, res_d;
  logic         ser_q, ser_d;
  logic [W-1:0] onehot, below, work;
  logic         en;

  always_comb begin
    onehot = W'(1) << pos_i;
    below  = onehot - W'(1);
    work   = code_q;
    if (cmp_below_i) work = code_q & ~onehot;

    code_d = code_q;
    res_d  = res_q;
    ser_d  = ser_q;
    if (rise_i) begin
      code_d = PRESET;
      res_d  = PRESET;
      ser_d  = 1'b0;
    end else if (fall_i) begin
      code_d = MSB_ONE;
    end else if (busy_i) begin
      ser_d = ~cmp_below_i;
      if (last_i) begin
        code_d = work | below;
        res_d  = work | below;
      end else begin
        code_d = work | (onehot >> 1);
      end
    end
  end

  assign en = rise_i | fall_i | busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= PRESET;
      res_q  <= PRESET;
      ser_q  <= 1'b0;
    end else if (en) begin
      code_q <= code_d;
      res_q  <= res_d;
      ser_q  <= ser_d;
    end
  end

  assign trial_o  = code_q;
  assign result_o = res_q;
  assign ser_o    = ser_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_below_i,
  input  logic [1:0]   res_sel_i,
  input  logic         twos_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] result_o,
  output logic         eoc_o,
  output logic         ser_o,
  output logic         ser_n_o
);
  localparam int IW = $clog2(W);

  logic          rise, fall, busy, last;
  logic [IW-1:0] pos;
  logic [W-1:0]  result_raw;

  sar_start_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  sar_sequencer #(.W(W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .fall_i   (fall),
    .res_sel_i(res_sel_i),
    .busy_o   (busy),
    .pos_o    (pos),
    .last_o   (last)
  );

  sar_datapath #(.W(W)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .busy_i     (busy),
    .last_i     (last),
    .pos_i      (pos),
    .cmp_below_i(cmp_below_i),
    .trial_o    (trial_o),
    .result_o   (result_raw),
    .ser_o      (ser_o)
  );

  assign eoc_o    = busy;
  assign ser_n_o  = ~ser_o;
  assign result_o = {result_raw[W-1] ^ twos_i, result_raw[W-2:0]};
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [1:0]   res_sel_i,
  input logic         eoc_o,
  input logic [W-1:0] result_q
);
  localparam int CW = $clog2(W + 1) + 1;

  logic          st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      cnt_q <= '0;
      nb_q  <= '0;
    end else begin
      st_q <= start_i;
      if (st_q && !start_i) begin
        cnt_q <= '0;
        nb_q  <= CW'(sar_pkg::bits_for_sel(W, res_sel_i));
      end else if (eoc_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !start_i) |=> eoc_o);

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !eoc_o);

  // R7
  result_busy_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && $past(eoc_o)) |-> $stable(result_q));

  // R7
  result_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && !start_i) |=> $stable(result_q));

  // R5
  eoc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eoc_o) && !$past(start_i)) |-> (cnt_q == nb_q));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .res_sel_i(res_sel_i),
  .eoc_o    (eoc_o),
  .result_q (result_raw)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int W      = 12;
  localparam int MAXC   = (1 << W) - 1;
  localparam int PRESET = (1 << (W - 1)) - 1;
  localparam int MSBV   = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         cmp_below;
  logic [1:0]   res_sel;
  logic         twos;
  logic [W-1:0] trial, result;
  logic         eoc, ser, ser_n;
  int           ain;   // analog input in half-LSB units
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;

  // ideal comparator: transition to code t lies at (t - 1/2) LSB
  always_comb cmp_below = ((2 * int'(trial)) - 1) > ain;

  sar_conv_ctrl #(.W(W)) i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_below_i(cmp_below),
    .res_sel_i(res_sel), .twos_i(twos), .trial_o(trial), .result_o(result),
    .eoc_o(eoc), .ser_o(ser), .ser_n_o(ser_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int nbits(input int sel);
    if (sel == 1) return W - 2;
    if (sel == 2) return W - 4;
    return W;
  endfunction

  function automatic int exp_code(input int a, input int n);
    int full;
    int m;
    full = (a + 1) >> 1;
    if (full > MAXC) full = MAXC;
    m = W - n;
    return ((full >> m) << m) | ((1 << m) - 1);
  endfunction

  // One conversion; sel_late >= 0 changes res_sel after the launch edge.
  task automatic run_conv(input int a, input int sel, input bit tw, input int sel_late);
    int n, e, cnt, serw, pairbad, tv;
    ain = a; res_sel = 2'(sel); twos = tw;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    if (sel_late >= 0) res_sel = 2'(sel_late);
    tv = tw ? MSBV : 0;
    n = nbits(sel);
    e = exp_code(a, n);
    chk("R3 eoc high after launch", int'(eoc), 1);
    chk("R7 result held at preset during conversion", int'(result), PRESET ^ tv);
    chk("R4 first trial is MSB alone", int'(trial), MSBV);
    cnt = 0; serw = 0; pairbad = 0;
    while (eoc && cnt < W + 4) begin
      @(negedge clk);
      cnt++;
      serw = (serw << 1) | int'(ser);
      if (ser_n == ser) pairbad++;
    end
    chk("R3 R5 eoc length in cycles", cnt, n);
    chk("R6 serial stream MSB first", serw, e >> (W - n));
    chk("R6 complementary stream", pairbad, 0);
    chk("R4 R5 R8 parallel result", int'(result), e ^ tv);
    repeat (3) @(negedge clk);
    chk("R7 result stable while idle", int'(result), e ^ tv);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; start = 1'b0; res_sel = 2'd0; twos = 1'b0; ain = 0;
    repeat (3) @(negedge clk);
    chk("R1 eoc in reset", int'(eoc), 0);
    chk("R1 result in reset", int'(result), PRESET);
    chk("R1 trial in reset", int'(trial), PRESET);
    chk("R1 ser in reset", int'(ser), 0);
    chk("R1 ser_n in reset", int'(ser_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_hold;
    run_conv(5000, 0, 1'b0, -1);
    @(negedge clk) start = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 eoc low while start held", int'(eoc), 0);
    chk("R2 trial preset", int'(trial), PRESET);
    chk("R2 result preset", int'(result), PRESET);
    chk("R2 ser cleared", int'(ser), 0);
    start = 1'b0;
    for (int i = 0; i < W + 4 && !(i > 0 && !eoc); i++) @(negedge clk);
  endtask

  task automatic test_abort;
    ain = 3000; res_sel = 2'd0; twos = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 conversion running before abort", int'(eoc), 1);
    start = 1'b1;
    @(negedge clk);
    chk("R9 eoc low after abort", int'(eoc), 0);
    chk("R9 trial preset after abort", int'(trial), PRESET);
    chk("R9 result preset after abort", int'(result), PRESET);
    run_conv(3000, 0, 1'b0, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    test_reset();
    // corners, full resolution
    run_conv(0, 0, 1'b0, -1);
    run_conv(1, 0, 1'b0, -1);
    run_conv(2, 0, 1'b0, -1);
    run_conv(3, 0, 1'b0, -1);
    run_conv((1 << W) - 1, 0, 1'b0, -1);
    run_conv(1 << W, 0, 1'b1, -1);
    run_conv((1 << (W + 1)) - 1, 0, 1'b0, -1);
    run_conv((1 << (W + 1)) - 1, 0, 1'b1, -1);
    // short cycle corners
    run_conv(0, 1, 1'b0, -1);
    run_conv((1 << (W + 1)) - 1, 2, 1'b0, -1);
    test_hold();
    test_abort();
    // R10: late change of res_sel is ignored
    run_conv(4321, 0, 1'b0, 2);
    run_conv(4321, 2, 1'b0, 0);
    // random inputs at every short-cycle setting
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 6; k++) begin
        run_conv(int'($urandom_range((1 << (W + 1)) - 1, 0)), s, 1'($urandom_range(1, 0)), -1);
      end
    end
    report();
    $finish;
  end
endmodule